// File: doc/BRIEF.md
# Serial Port Interrupt and Receive Timeout Unit

This block produces the interrupt conditions of a synchronous serial port controller and merges them into one interrupt line. It watches the fill levels of the receive and transmit FIFOs, a strobe that marks a complete incoming frame, and a strobe that marks a read from the receive FIFO. From these it derives four conditions:

- a sticky receive overrun flag;
- a sticky receive timeout flag;
- a receive half-full level;
- a transmit half-empty level.

A small register file holds the bit-rate prescaler and the per-condition enables. Through the same interface software reads raw and enabled status and clears the two sticky flags.

The receive timeout is measured in serial bit periods, not in system clocks. An internal divider turns the peripheral clock into a bit tick. Its period is the prescaler value times (serial rate + 1). A state machine counts 32 such ticks while receive data sits unread.

The machine has three states:

- `TO_IDLE`: the receive FIFO is empty.
- `TO_COUNT`: data is waiting and ticks are being counted.
- `TO_FIRED`: the timeout flag is raised.

Its transitions are:

- *arm*: `TO_IDLE` to `TO_COUNT` when the FIFO becomes non-empty.
- *drain*: `TO_COUNT` to `TO_IDLE` when the FIFO empties.
- *restart*: `TO_COUNT` to itself on a read or a new frame; the count is zeroed.
- *expire*: `TO_COUNT` to `TO_FIRED` on the 32nd tick.
- *release*: `TO_FIRED` to `TO_COUNT` or `TO_IDLE` on a software clear, chosen by whether data remains.

Top module: `ssp_irq_unit`

## Requirements
- R1: A write to address 0 stores the written byte with bit 0 forced to 0 as the prescaler. Address 0 reads that value back.
- R2: With prescaler C (non-zero) and serial rate S, the timeout flag rises exactly 32·C·(S+1) clock edges after the timeout machine enters `TO_COUNT`. This holds while the receive level stays non-zero and no read or frame strobe occurs.
- R3: A frame strobe while the receive-full input is high sets the overrun flag at the next edge. A frame strobe without receive-full does not set it.
- R4: The overrun and timeout flags stay set until a write to address 4 with 1 in bit 0 (overrun) or bit 1 (timeout). An overrun set and clear in the same cycle leaves the flag set.
- R5: A receive-read or frame strobe during counting restarts the full 32-period window from that edge. A receive level of 0 stops counting.
- R6: The receive condition is 1 while the receive level is at least DEPTH/2. The transmit condition is 1 while the transmit level is at most DEPTH/2. Both follow the levels with no memory.
- R7: Address 1 holds the four enable bits in bits [3:0] and reads 0 in bits [7:4].
- R8: Address 2 reads the raw conditions regardless of the enables: bit 0 overrun, bit 1 timeout, bit 2 receive, bit 3 transmit, bits [7:4] zero.
- R9: Address 3 reads raw status AND enables. The `irq` output is the OR of those four bits.
- R10: While the prescaler is 0, the bit divider is idle and no timeout is raised.
- R11: After reset the prescaler, enables and both sticky flags are 0, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 prescaler, 1 enables, 2 raw, 3 enabled status, 4 clear) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| serial_rate | input | 8 | Serial rate field S; bit period is prescaler·(S+1) clocks |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill level |
| rx_full | input | 1 | Receive FIFO full |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO fill level |
| frame_done | input | 1 | One-cycle strobe: a frame has been received |
| rx_read | input | 1 | One-cycle strobe: the receive FIFO was read |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest point to reach is the exact edge at which the timeout fires after a restart. This needs data held in the receive FIFO for more than a hundred cycles, with a read strobe placed in the middle of the window. The stimulus arms the machine with a small prescaler and rate so that one window is 128 clocks. It then drops a read strobe at cycle 100, and samples the raw status on the edge before and the edge of expiry.

A second hard case is a clear that lands while data is still present. This must re-arm a fresh window rather than return to idle. The bench releases the flag with the level held non-zero and times the second expiry from the clear.

A behavioural model in the bench tracks flags and counts, and is compared on every clock against the status read port and `irq`.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

    localparam logic [2:0] ADDR_PRESCALE = 3'd0;
    localparam logic [2:0] ADDR_ENABLE   = 3'd1;
    localparam logic [2:0] ADDR_RAW      = 3'd2;
    localparam logic [2:0] ADDR_MASKED   = 3'd3;
    localparam logic [2:0] ADDR_CLEAR    = 3'd4;

    localparam int BIT_OVR = 0;
    localparam int BIT_TO  = 1;
    localparam int BIT_RX  = 2;
    localparam int BIT_TX  = 3;
    localparam int NUM_COND = 4;

endpackage

// File: rtl/ssp_bit_divider.sv
module ssp_bit_divider #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PRE_W-1:0]  divisor,
    input  logic [RATE_W-1:0] rate,
    output logic              bit_tick
);

    logic [PRE_W-1:0]  pre_cnt;
    logic [RATE_W-1:0] rate_cnt;
    logic              pre_last;

    assign pre_last = (pre_cnt == divisor - PRE_W'(1));
    assign bit_tick = !clr && pre_last && (rate_cnt == rate);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
        end else if (pre_last) begin
            pre_cnt  <= '0;
            rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + RATE_W'(1);
        end else begin
            pre_cnt  <= pre_cnt + PRE_W'(1);
        end
    end

endmodule

// File: rtl/ssp_rx_timeout_fsm.sv
module ssp_rx_timeout_fsm
    import ssp_irq_pkg::*;
#(
    parameter int TO_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_nonempty,
    input  logic restart,
    input  logic div_ok,
    input  logic bit_tick,
    input  logic clr_flag,
    output logic div_clr,
    output logic timeout
);

    localparam int CNT_W = (TO_BITS > 1) ? $clog2(TO_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TO_BITS - 1);

    to_state_e        state, state_nx;
    logic [CNT_W-1:0] tick_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TO_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TO_IDLE:  if (rx_nonempty) state_nx = TO_COUNT;
            TO_COUNT: begin
                if (!rx_nonempty)
                    state_nx = TO_IDLE;
                else if (!restart && bit_tick && tick_cnt == CNT_LAST)
                    state_nx = TO_FIRED;
            end
            TO_FIRED: if (clr_flag) state_nx = rx_nonempty ? TO_COUNT : TO_IDLE;
            default:  state_nx = TO_IDLE;
        endcase
    end

    always_comb begin
        div_clr = (state != TO_COUNT) || restart || !div_ok;
        timeout = (state == TO_FIRED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || div_clr)
            tick_cnt <= '0;
        else if (bit_tick)
            tick_cnt <= (tick_cnt == CNT_LAST) ? '0 : tick_cnt + CNT_W'(1);
    end

endmodule

// File: rtl/ssp_irq_regs.sv
module ssp_irq_regs
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [LVL_W-1:0]    rx_level,
    input  logic                rx_full,
    input  logic [LVL_W-1:0]    tx_level,
    input  logic                frame_done,
    input  logic                timeout_flag,
    output logic [7:0]          prescale,
    output logic                clr_timeout,
    output logic [NUM_COND-1:0] enable,
    output logic [NUM_COND-1:0] raw,
    output logic                irq
);

    localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

    logic       ovr_q;
    logic       wr_clear;
    logic [NUM_COND-1:0] masked;

    assign wr_clear    = reg_wr && (reg_addr == ADDR_CLEAR);
    assign clr_timeout = wr_clear && reg_wdata[BIT_TO];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale <= '0;
            enable   <= '0;
            ovr_q    <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_PRESCALE)
                prescale <= {reg_wdata[7:1], 1'b0};
            if (reg_wr && reg_addr == ADDR_ENABLE)
                enable <= reg_wdata[NUM_COND-1:0];
            if (frame_done && rx_full)
                ovr_q <= 1'b1;
            else if (wr_clear && reg_wdata[BIT_OVR])
                ovr_q <= 1'b0;
        end
    end

    always_comb begin
        raw          = '0;
        raw[BIT_OVR] = ovr_q;
        raw[BIT_TO]  = timeout_flag;
        raw[BIT_RX]  = (rx_level >= HALF);
        raw[BIT_TX]  = (tx_level <= HALF);
        masked       = raw & enable;
        irq          = |masked;
    end

    always_comb begin
        case (reg_addr)
            ADDR_PRESCALE: reg_rdata = prescale;
            ADDR_ENABLE:   reg_rdata = {4'b0, enable};
            ADDR_RAW:      reg_rdata = {4'b0, raw};
            ADDR_MASKED:   reg_rdata = {4'b0, masked};
            default:       reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/ssp_irq_unit.sv
module ssp_irq_unit
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int TO_BITS = 32,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [7:0]       serial_rate,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_full,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             frame_done,
    input  logic             rx_read,
    output logic             irq
);

    logic [7:0]          prescale_q;
    logic [NUM_COND-1:0] enable_q;
    logic [NUM_COND-1:0] raw_q;
    logic                clr_timeout;
    logic                div_clr;
    logic                bit_tick;
    logic                timeout_flag;

    ssp_irq_regs #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rx_level     (rx_level),
        .rx_full      (rx_full),
        .tx_level     (tx_level),
        .frame_done   (frame_done),
        .timeout_flag (timeout_flag),
        .prescale     (prescale_q),
        .clr_timeout  (clr_timeout),
        .enable       (enable_q),
        .raw          (raw_q),
        .irq          (irq)
    );

    ssp_bit_divider #(.PRE_W(8), .RATE_W(8)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (div_clr),
        .divisor  (prescale_q),
        .rate     (serial_rate),
        .bit_tick (bit_tick)
    );

    ssp_rx_timeout_fsm #(.TO_BITS(TO_BITS)) u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_nonempty (rx_level != '0),
        .restart     (rx_read || frame_done),
        .div_ok      (prescale_q != 8'h00),
        .bit_tick    (bit_tick),
        .clr_flag    (clr_timeout),
        .div_clr     (div_clr),
        .timeout     (timeout_flag)
    );

endmodule

// File: rtl/ssp_irq_checker.sv
module ssp_irq_checker #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_full,
    input logic             frame_done,
    input logic             irq,
    input logic [7:0]       prescale_q,
    input logic [3:0]       enable_q,
    input logic [3:0]       raw_q
);

    logic clr_ovr_wr, clr_to_wr;
    assign clr_ovr_wr = reg_wr && reg_addr == 3'd4 && reg_wdata[0];
    assign clr_to_wr  = reg_wr && reg_addr == 3'd4 && reg_wdata[1];

    AST_PRESCALE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0) |=> (prescale_q == ($past(reg_wdata) & 8'hFE))); // R1
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_full) |=> raw_q[0]); // R3
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[0] && !clr_ovr_wr) |=> raw_q[0]); // R4
    AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[1] && clr_to_wr) |=> !raw_q[1]); // R4
    AST_TO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q[1]) |-> ($past(rx_level) != '0)); // R2
    AST_NO_TO_UNSCALED: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale_q == 8'h00 && !raw_q[1]) |=> !raw_q[1]); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == 4'h0) |-> !irq); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd2) |-> (reg_rdata[7:4] == 4'h0)); // R8

endmodule

bind ssp_irq_unit ssp_irq_checker #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rx_level   (rx_level),
    .rx_full    (rx_full),
    .frame_done (frame_done),
    .irq        (irq),
    .prescale_q (prescale_q),
    .enable_q   (enable_q),
    .raw_q      (raw_q)
);

// File: tb/tb_ssp_irq_unit.sv
module tb_ssp_irq_unit;

    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd2;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [7:0]    serial_rate = 8'd0;
    logic [LW-1:0] rx_level = '0;
    logic          rx_full = 1'b0;
    logic [LW-1:0] tx_level = LW'(DEPTH);
    logic          frame_done = 1'b0;
    logic          rx_read = 1'b0;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit live = 1'b0;

    ssp_irq_unit #(.DEPTH(DEPTH)) dut (.*);

    always #5 clk = ~clk;

    // behavioural reference model
    int   m_cpsr, m_en, m_state, m_k;
    bit   m_ovr;

    function automatic int m_raw();
        int r;
        r = (m_ovr ? 1 : 0) | ((m_state == 2) ? 2 : 0)
          | ((int'(rx_level) >= DEPTH/2) ? 4 : 0)
          | ((int'(tx_level) <= DEPTH/2) ? 8 : 0);
        return r;
    endfunction

    function automatic int m_read(input int a);
        case (a)
            0: return m_cpsr;
            1: return m_en;
            2: return m_raw();
            3: return m_raw() & m_en;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cpsr = 0; m_en = 0; m_ovr = 0; m_state = 0; m_k = 0;
        end else begin
            int period;
            period = m_cpsr * (int'(serial_rate) + 1);
            case (m_state)
                0: if (rx_level != 0) begin m_state = 1; m_k = 0; end
                1: begin
                    if (rx_level == 0) m_state = 0;
                    else if (rx_read || frame_done || m_cpsr == 0) m_k = 0;
                    else begin
                        m_k++;
                        if (m_k == 32 * period) m_state = 2;
                    end
                end
                default: if (reg_wr && reg_addr == 4 && reg_wdata[1]) begin
                    m_state = (rx_level != 0) ? 1 : 0; m_k = 0;
                end
            endcase
            if (frame_done && rx_full) m_ovr = 1;
            else if (reg_wr && reg_addr == 4 && reg_wdata[0]) m_ovr = 0;
            if (reg_wr && reg_addr == 0) m_cpsr = int'(reg_wdata) & 8'hFE;
            if (reg_wr && reg_addr == 1) m_en = int'(reg_wdata) & 4'hF;
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (live && !finished) begin
            check(int'(reg_rdata), m_read(int'(reg_addr)), "R8 read port vs model");
            check(int'(irq), (m_raw() & m_en) != 0 ? 1 : 0, "R9 irq vs model");
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0; reg_addr = 3'd2; reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic [2:0] a, input int exp, input string tag);
        reg_addr = a;
        #1;
        check(int'(reg_rdata), exp, tag);
        reg_addr = 3'd2;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        live = 1'b1;
        // R11 reset state
        rd(0, 0, "R11 prescale after reset");
        rd(1, 0, "R11 enables after reset");
        rd(2, 0, "R11 raw after reset");
        rd(5, 0, "R11 unused address");
        check(int'(irq), 0, "R11 irq after reset");

        // R1 even prescaler
        wr(0, 8'h07); rd(0, 8'h06, "R1 odd write 7");
        wr(0, 8'hFF); rd(0, 8'hFE, "R1 odd write FF");

        // R7 enables
        wr(1, 8'hFF); rd(1, 8'h0F, "R7 enable upper bits zero");
        wr(1, 8'h00);

        // R6 level conditions
        wr(0, 8'h00);
        rx_level = 3; step(1); rd(2, 0, "R6 rx below half");
        rx_level = 4; step(1); rd(2, 4, "R6 rx at half");
        rx_level = 0; tx_level = 5; step(1); rd(2, 0, "R6 tx above half");
        tx_level = 4; step(1); rd(2, 8, "R6 tx at half");
        tx_level = 0; step(1); rd(2, 8, "R6 tx empty");
        tx_level = LW'(DEPTH); step(1); rd(2, 0, "R6 tx full clears");

        // R3 / R4 overrun
        rx_level = 8; rx_full = 1'b1; frame_done = 1'b1; step(1); frame_done = 1'b0;
        rd(2, 5, "R3 overrun set");
        step(5); rd(2, 5, "R4 overrun sticky");
        wr(4, 8'h01); rd(2, 4, "R4 overrun cleared");
        rx_full = 1'b0; frame_done = 1'b1; step(1); frame_done = 1'b0;
        rd(2, 4, "R3 frame without full");
        rx_full = 1'b1; frame_done = 1'b1; wr(4, 8'h01); frame_done = 1'b0;
        rd(2, 5, "R4 set wins over clear");
        wr(4, 8'h01); rx_full = 1'b0; rx_level = 0; step(1);

        // R9 enabled status and irq
        wr(1, 8'h04); rd(3, 0, "R9 masked with rx low");
        check(int'(irq), 0, "R9 irq low");
        rx_level = 5; step(1);
        rd(3, 4, "R9 masked rx");
        check(int'(irq), 1, "R9 irq high");
        rx_level = 0; wr(1, 8'h00); step(1);

        // R10 prescaler zero: no timeout
        rx_level = 2; step(2000);
        rd(2, 0, "R10 no timeout with zero prescaler");
        rx_level = 0; step(2);

        // R2 exact timeout: C=2, S=1 -> 128 clocks
        wr(0, 8'h02); serial_rate = 8'd1; wr(1, 8'h02);
        rx_level = 1; step(1);
        step(127); rd(2, 0, "R2 one edge before expiry");
        step(1);   rd(2, 2, "R2 expiry edge");
        check(int'(irq), 1, "R2 irq on timeout");

        // R4 clear with data present re-arms
        wr(4, 8'h02); rd(2, 0, "R4 timeout cleared");
        step(127); rd(2, 0, "R4 rearm before expiry");
        step(1);   rd(2, 2, "R4 rearm expiry");
        wr(4, 8'h02);

        // R5 restart by read mid window
        step(100);
        rx_read = 1'b1; step(1); rx_read = 1'b0;
        step(127); rd(2, 0, "R5 restart extends window");
        step(1);   rd(2, 2, "R5 expiry after restart");

        // R5 draining stops counting
        rx_level = 0; wr(4, 8'h02);
        step(300); rd(2, 0, "R5 empty fifo no timeout");

        // R2 second ratio: C=4, S=0 -> 128 clocks
        wr(0, 8'h04); serial_rate = 8'd0;
        rx_level = 3; step(1);
        step(127); rd(2, 0, "R2 ratio two before expiry");
        step(1);   rd(2, 2, "R2 ratio two expiry");
        rx_level = 0; wr(4, 8'h02); step(4);

        summary();
    end

endmodule